// File: doc/BRIEF.md
# USB Side-Band Wake Register Block

This block sits beside a USB dual-role controller and watches the slow side-band signals from the analog front end. These are the two-bit VBUS comparator code, the ID pin and the two data-line levels. Each input is asynchronous and passes through a synchronizer before use. The block reports the filtered levels in a single 32-bit control and status word. It keeps a sticky change flag for each of three sources (VBUS-valid, ID and the line state) and can raise a wake interrupt from those flags.

Software can override the ID value and the VBUS-valid value that the controller core sees, using two-bit force fields. It can also enable the ID pull-up, the line pull-up and the oscillator, which leave the block as plain control outputs. Access is through one 32-bit word. A write takes effect at the clock edge on which `reg_we_i` is high. The read data is always present on `reg_rdata_o`.

The change flags are write-1-to-clear. A read-modify-write of the control bits that writes a flag back as 0 therefore never loses a pending event.

Top module: `otg_sideband_wake`

## Requirements
- R1: Change flags sit in bits 0 (VBUS-valid), 1 (ID) and 2 (line state) and are sticky. A write with 1 in a flag bit clears that flag. A write with 0 in a flag bit leaves the flag as it was.
- R2: Detect enables sit in bits 3, 4 and 5, one per flag in the same order. A flag is set one clock edge after its source value changes, but only while its enable reads 1. With the enable at 0, a change leaves the flag untouched.
- R3: The ID force field is bits 9:8. Code 10 forces the ID seen by the core to 0 (host). Code 11 forces it to 1 (device). Codes 00 and 01 pass the synchronized pin. `id_core_o` and status bit 18 both show this merged ID.
- R4: The VBUS-valid force field is bits 11:10 and uses the same codes as the ID field. The unforced VBUS-valid value is 1 exactly when the synchronized level code is 11. `vbus_valid_o` shows the merged value, and that merged value is the source for flag 0.
- R5: `wake_irq_o` is 1 exactly when the global interrupt enable (bit 6) is 1 and at least one change flag is 1.
- R6: If a clear write to a flag falls on the same clock edge as a new change event for that flag, the flag stays set.
- R7: Status bits 16 (DM), 17 (DP) and 21:20 (VBUS level code: 00 below session end, 01 above session end, 10 above A-valid, 11 above VBUS-valid) show the inputs after a two-flop synchronizer. An input change becomes visible after two clock edges.
- R8: Bits 12 (ID pull-up), 13 (line pull-up) and 14 (oscillator) are read/write and drive `id_pullup_en_o`, `line_pullup_en_o` and `osc_en_o`.
- R9: After reset, every register field is 0. Bits 7, 15, 19 and 31:22 always read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Block clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| reg_we_i | input | 1 | Write strobe for the control word |
| reg_wdata_i | input | 32 | Write data |
| reg_rdata_o | output | 32 | Read data: control fields, flags and status |
| vbus_lvl_i | input | 2 | Asynchronous VBUS comparator code |
| id_pin_i | input | 1 | Asynchronous ID pin level |
| dp_i | input | 1 | Asynchronous D+ line level |
| dm_i | input | 1 | Asynchronous D- line level |
| id_core_o | output | 1 | ID value after override, to the core |
| vbus_valid_o | output | 1 | VBUS-valid after override, to the core |
| wake_irq_o | output | 1 | Wake interrupt |
| id_pullup_en_o | output | 1 | ID pull-up enable |
| line_pullup_en_o | output | 1 | Data-line pull-up enable |
| osc_en_o | output | 1 | Oscillator enable |

## Verification
The bench drives random pin toggles and random full-word writes. Because these include every force code and random clear masks, flag setting is exercised under enabled and disabled detection, and both through pin edges and through override edges. Directed sequences isolate four cases:
- writing 0 to a pending flag versus writing 1 to it;
- a clear that lands on the same edge as a new event;
- a forced VBUS-valid value that opposes the pin level;
- the reset word.

These cases separate a plain-write flag from a true write-1-to-clear flag. They also show whether the edge source is taken before or after the override.

// File: rtl/otg_wake_pkg.sv
package otg_wake_pkg;

    localparam int NSRC      = 3;
    localparam int SRC_VBUS  = 0;
    localparam int SRC_ID    = 1;
    localparam int SRC_LINE  = 2;

    localparam int FLAG_LSB  = 0;
    localparam int DEN_LSB   = 3;
    localparam int GIE_BIT   = 6;
    localparam int FID_LSB   = 8;
    localparam int FVB_LSB   = 10;
    localparam int PUID_BIT  = 12;
    localparam int PULN_BIT  = 13;
    localparam int OSC_BIT   = 14;
    localparam int DM_BIT    = 16;
    localparam int DP_BIT    = 17;
    localparam int MID_BIT   = 18;
    localparam int VLVL_LSB  = 20;

    localparam int RAW_W     = 5;   // {vbus[1:0], id, dp, dm}

    typedef struct packed {
        logic [NSRC-1:0] flag;
        logic [NSRC-1:0] den;
        logic            gie;
        logic [1:0]      fid;
        logic [1:0]      fvb;
        logic            pu_id;
        logic            pu_line;
        logic            osc;
    } wake_regs_t;

endpackage

// File: rtl/owk_sync.sv
module owk_sync #(
    parameter int W      = 1,
    parameter int STAGES = 2
) (
    input  logic         clk_i,
    input  logic         rst_ni,
    input  logic [W-1:0] async_i,
    output logic [W-1:0] sync_o
);
    logic [STAGES-1:0][W-1:0] chain_d, chain_q;

    always_comb begin
        chain_d[0] = async_i;
        for (int k = 1; k < STAGES; k++) begin
            chain_d[k] = chain_q[k-1];
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) chain_q <= '0;
        else         chain_q <= chain_d;
    end

    assign sync_o = chain_q[STAGES-1];
endmodule

// File: rtl/owk_force.sv
module owk_force (
    input  logic [1:0] mode_i,
    input  logic       raw_i,
    output logic       val_o
);
    // mode[1] selects the override, mode[0] is the forced level
    always_comb begin
        if (mode_i[1]) val_o = mode_i[0];
        else           val_o = raw_i;
    end
endmodule

// File: rtl/owk_edge.sv
module owk_edge #(
    parameter int W = 1
) (
    input  logic         clk_i,
    input  logic         rst_ni,
    input  logic [W-1:0] cur_i,
    output logic         chg_o
);
    logic [W-1:0] prev_d, prev_q;

    always_comb begin
        prev_d = cur_i;
        chg_o  = (cur_i != prev_q);
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) prev_q <= '0;
        else         prev_q <= prev_d;
    end
endmodule

// File: rtl/otg_sideband_wake.sv
module otg_sideband_wake
    import otg_wake_pkg::*;
#(
    parameter int REG_W       = 32,
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             reg_we_i,
    input  logic [REG_W-1:0] reg_wdata_i,
    output logic [REG_W-1:0] reg_rdata_o,
    input  logic [1:0]       vbus_lvl_i,
    input  logic             id_pin_i,
    input  logic             dp_i,
    input  logic             dm_i,
    output logic             id_core_o,
    output logic             vbus_valid_o,
    output logic             wake_irq_o,
    output logic             id_pullup_en_o,
    output logic             line_pullup_en_o,
    output logic             osc_en_o
);
    localparam int NFORCE = 2;

    wake_regs_t r_d, r_q;

    logic [RAW_W-1:0] raw_sync;
    logic [1:0]       vlvl_s;
    logic             id_s, dp_s, dm_s;

    logic [NFORCE-1:0]      frc_raw, frc_val;
    logic [NFORCE-1:0][1:0] frc_mode;
    logic [NSRC-1:0][1:0]   src_val;
    logic [NSRC-1:0]        chg;

    logic unused_wdata;
    assign unused_wdata = ^{reg_wdata_i[REG_W-1:OSC_BIT+1], reg_wdata_i[GIE_BIT+1]};

    owk_sync #(.W(RAW_W), .STAGES(SYNC_STAGES)) u_sync (
        .clk_i   (clk_i),
        .rst_ni  (rst_ni),
        .async_i ({vbus_lvl_i, id_pin_i, dp_i, dm_i}),
        .sync_o  (raw_sync)
    );

    assign vlvl_s = raw_sync[4:3];
    assign id_s   = raw_sync[2];
    assign dp_s   = raw_sync[1];
    assign dm_s   = raw_sync[0];

    // override slot 0: VBUS-valid, slot 1: ID
    assign frc_raw  = {id_s, &vlvl_s};
    assign frc_mode = {r_q.fid, r_q.fvb};

    for (genvar g = 0; g < NFORCE; g++) begin : g_force
        owk_force u_force (
            .mode_i (frc_mode[g]),
            .raw_i  (frc_raw[g]),
            .val_o  (frc_val[g])
        );
    end

    assign src_val[SRC_VBUS] = {1'b0, frc_val[0]};
    assign src_val[SRC_ID]   = {1'b0, frc_val[1]};
    assign src_val[SRC_LINE] = {dp_s, dm_s};

    for (genvar s = 0; s < NSRC; s++) begin : g_edge
        owk_edge #(.W(2)) u_edge (
            .clk_i  (clk_i),
            .rst_ni (rst_ni),
            .cur_i  (src_val[s]),
            .chg_o  (chg[s])
        );
    end

    always_comb begin
        r_d = r_q;
        for (int s = 0; s < NSRC; s++) begin
            // a new event outranks a clear on the same edge
            r_d.flag[s] = (r_q.flag[s] & ~(reg_we_i & reg_wdata_i[FLAG_LSB+s]))
                        | (chg[s] & r_q.den[s]);
        end
        if (reg_we_i) begin
            r_d.den     = reg_wdata_i[DEN_LSB +: NSRC];
            r_d.gie     = reg_wdata_i[GIE_BIT];
            r_d.fid     = reg_wdata_i[FID_LSB +: 2];
            r_d.fvb     = reg_wdata_i[FVB_LSB +: 2];
            r_d.pu_id   = reg_wdata_i[PUID_BIT];
            r_d.pu_line = reg_wdata_i[PULN_BIT];
            r_d.osc     = reg_wdata_i[OSC_BIT];
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) r_q <= '0;
        else         r_q <= r_d;
    end

    always_comb begin
        reg_rdata_o                         = '0;
        reg_rdata_o[FLAG_LSB +: NSRC]       = r_q.flag;
        reg_rdata_o[DEN_LSB +: NSRC]        = r_q.den;
        reg_rdata_o[GIE_BIT]                = r_q.gie;
        reg_rdata_o[FID_LSB +: 2]           = r_q.fid;
        reg_rdata_o[FVB_LSB +: 2]           = r_q.fvb;
        reg_rdata_o[PUID_BIT]               = r_q.pu_id;
        reg_rdata_o[PULN_BIT]               = r_q.pu_line;
        reg_rdata_o[OSC_BIT]                = r_q.osc;
        reg_rdata_o[DM_BIT]                 = dm_s;
        reg_rdata_o[DP_BIT]                 = dp_s;
        reg_rdata_o[MID_BIT]                = frc_val[1];
        reg_rdata_o[VLVL_LSB +: 2]          = vlvl_s;
    end

    assign id_core_o        = frc_val[1];
    assign vbus_valid_o     = frc_val[0];
    assign wake_irq_o       = r_q.gie & (|r_q.flag);
    assign id_pullup_en_o   = r_q.pu_id;
    assign line_pullup_en_o = r_q.pu_line;
    assign osc_en_o         = r_q.osc;
endmodule

// File: rtl/owk_checker.sv
module owk_checker (
    input logic        clk_i,
    input logic        rst_ni,
    input logic        reg_we_i,
    input logic [31:0] reg_wdata_i,
    input logic [31:0] reg_rdata_o,
    input logic        id_core_o,
    input logic        vbus_valid_o,
    input logic        wake_irq_o,
    input logic        osc_en_o
);
    for (genvar i = 0; i < 3; i++) begin : g_flag
        // R1: a pending flag survives any write that does not put 1 in it
        p_flag_sticky_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
            reg_rdata_o[i] && !(reg_we_i && reg_wdata_i[i]) |=> reg_rdata_o[i]);
        // R2: with detection off a clear flag cannot become set
        p_flag_needs_en_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
            !reg_rdata_o[3+i] && !reg_rdata_o[i] |=> !reg_rdata_o[i]);
    end

    p_id_force_low_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
        reg_rdata_o[9:8] == 2'b10 |-> !id_core_o && !reg_rdata_o[18]);
    p_id_force_high_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
        reg_rdata_o[9:8] == 2'b11 |-> id_core_o && reg_rdata_o[18]);
    p_vbus_force_low_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
        reg_rdata_o[11:10] == 2'b10 |-> !vbus_valid_o);
    p_vbus_force_high_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
        reg_rdata_o[11:10] == 2'b11 |-> vbus_valid_o);
    p_irq_gated_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
        wake_irq_o |-> reg_rdata_o[6] && (reg_rdata_o[2:0] != 3'b000));
    p_osc_follows_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
        reg_we_i |=> osc_en_o == $past(reg_wdata_i[14]));
    p_reserved_zero_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
        reg_rdata_o[31:22] == 10'd0 && !reg_rdata_o[19] && !reg_rdata_o[15] && !reg_rdata_o[7]);
endmodule

bind otg_sideband_wake owk_checker u_chk (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .reg_we_i     (reg_we_i),
    .reg_wdata_i  (reg_wdata_i),
    .reg_rdata_o  (reg_rdata_o),
    .id_core_o    (id_core_o),
    .vbus_valid_o (vbus_valid_o),
    .wake_irq_o   (wake_irq_o),
    .osc_en_o     (osc_en_o)
);

// File: tb/otg_sideband_wake_test.sv
module otg_sideband_wake_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        we = 1'b0;
    logic [31:0] wd = '0;
    logic [31:0] rd;
    logic [1:0]  vb = 2'b00;
    logic        idp = 1'b0, dp = 1'b0, dm = 1'b0;
    logic        id_core, vbus_valid, irq, pu_id, pu_ln, osc;

    int n_chk = 0;
    int n_err = 0;
    bit done = 0;

    always #10 clk = ~clk;

    otg_sideband_wake uut (
        .clk_i(clk), .rst_ni(rst_n), .reg_we_i(we), .reg_wdata_i(wd),
        .reg_rdata_o(rd), .vbus_lvl_i(vb), .id_pin_i(idp), .dp_i(dp), .dm_i(dm),
        .id_core_o(id_core), .vbus_valid_o(vbus_valid), .wake_irq_o(irq),
        .id_pullup_en_o(pu_id), .line_pullup_en_o(pu_ln), .osc_en_o(osc)
    );

    // reference model state
    bit [1:0] m1_vb, m2_vb;
    bit m1_id, m2_id, m1_dp, m2_dp, m1_dm, m2_dm;
    bit p_vv, p_id;
    bit [1:0] p_ln;
    bit [2:0] m_flag, m_den;
    bit m_gie, m_puid, m_puln, m_osc;
    bit [1:0] m_fid, m_fvb;

    function automatic bit apply_force(bit [1:0] mode, bit raw);
        return mode[1] ? mode[0] : raw;
    endfunction

    function automatic bit cur_id();
        return apply_force(m_fid, m2_id);
    endfunction

    function automatic bit cur_vv();
        return apply_force(m_fvb, m2_vb == 2'b11);
    endfunction

    function automatic logic [31:0] exp_word();
        logic [31:0] w = '0;
        w[2:0] = m_flag; w[5:3] = m_den; w[6] = m_gie;
        w[9:8] = m_fid; w[11:10] = m_fvb;
        w[12] = m_puid; w[13] = m_puln; w[14] = m_osc;
        w[16] = m2_dm; w[17] = m2_dp; w[18] = cur_id(); w[21:20] = m2_vb;
        return w;
    endfunction

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic model_tick(input bit w, input bit [31:0] d);
        bit [2:0] ev;
        bit cid, cvv;
        bit [1:0] cln;
        cid = cur_id(); cvv = cur_vv(); cln = {m2_dp, m2_dm};
        ev[0] = (cvv != p_vv) && m_den[0];
        ev[1] = (cid != p_id) && m_den[1];
        ev[2] = (cln != p_ln) && m_den[2];
        for (int i = 0; i < 3; i++)
            m_flag[i] = (m_flag[i] && !(w && d[i])) || ev[i];
        if (w) begin
            m_den = d[5:3]; m_gie = d[6]; m_fid = d[9:8]; m_fvb = d[11:10];
            m_puid = d[12]; m_puln = d[13]; m_osc = d[14];
        end
        p_vv = cvv; p_id = cid; p_ln = cln;
        m2_vb = m1_vb; m2_id = m1_id; m2_dp = m1_dp; m2_dm = m1_dm;
        m1_vb = vb; m1_id = idp; m1_dp = dp; m1_dm = dm;
    endtask

    task automatic compare_all();
        logic [31:0] e;
        e = exp_word();
        chk("R1 R2 R6 flags", {29'd0, rd[2:0]}, {29'd0, e[2:0]});
        chk("R2 detect enables", {29'd0, rd[5:3]}, {29'd0, e[5:3]});
        chk("R3 force id and merged id", {29'd0, rd[18], rd[9:8]}, {29'd0, e[18], e[9:8]});
        chk("R3 id_core", {31'd0, id_core}, {31'd0, cur_id()});
        chk("R4 vbus_valid", {31'd0, vbus_valid}, {31'd0, cur_vv()});
        chk("R5 wake_irq", {31'd0, irq}, {31'd0, m_gie && (m_flag != 0)});
        chk("R7 synced status", {28'd0, rd[21:20], rd[17:16]}, {28'd0, e[21:20], e[17:16]});
        chk("R8 enables", {26'd0, pu_id, pu_ln, osc, rd[14:12]},
            {26'd0, m_puid, m_puln, m_osc, e[14:12]});
        chk("R9 full word", rd, e);
    endtask

    task automatic cyc(input bit w, input bit [31:0] d);
        we = w; wd = d;
        @(posedge clk);
        model_tick(w, d);
        @(negedge clk);
        we = 1'b0;
        compare_all();
    endtask

    task automatic finish_run();
        done = 1;
        $display("  CHECKS %0d ERRORS %0d", n_chk, n_err);
        $finish;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_chk++; n_err++;
            $display("FAIL watchdog actual=running expected=finished");
            finish_run();
        end
    end

    initial begin
        void'($urandom(32'h5EED_1234));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R9: reset word
        chk("R9 reset word", rd, 32'h0);
        chk("R9 reset outputs", {26'd0, id_core, vbus_valid, irq, pu_id, pu_ln, osc}, 32'h0);

        // R2: enable all detection and global irq, raise ID pin
        cyc(1, 32'h0000_0078);
        idp = 1'b1;
        cyc(0, 0); cyc(0, 0); cyc(0, 0);
        chk("R2 id flag set", {31'd0, rd[1]}, 32'd1);
        chk("R5 irq asserted", {31'd0, irq}, 32'd1);
        // R1: write with zero in flag bits keeps it
        cyc(1, 32'h0000_0078);
        chk("R1 zero write keeps flag", {31'd0, rd[1]}, 32'd1);
        cyc(1, 32'h0000_007A);
        chk("R1 one write clears flag", {31'd0, rd[1]}, 32'd0);

        // R6: force id low, then clear on the edge that sees the change
        cyc(1, 32'h0000_0278);
        chk("R3 forced low", {31'd0, id_core}, 32'd0);
        cyc(1, 32'h0000_027A);
        chk("R6 event beats clear", {31'd0, rd[1]}, 32'd1);

        // R4: force VBUS-valid against the pins
        vb = 2'b00;
        cyc(1, 32'h0000_0C00);
        chk("R4 forced high", {31'd0, vbus_valid}, 32'd1);
        vb = 2'b11;
        cyc(0, 0); cyc(0, 0);
        cyc(1, 32'h0000_0800);
        chk("R4 forced low", {31'd0, vbus_valid}, 32'd0);
        cyc(1, 32'h0000_0000);
        chk("R4 pass through", {31'd0, vbus_valid}, 32'd1);

        // R8: enable outputs
        cyc(1, 32'h0000_7000);
        chk("R8 all enables", {29'd0, pu_id, pu_ln, osc}, 32'd7);

        // random mix
        for (int n = 0; n < 4000; n++) begin
            bit w;
            bit [31:0] d;
            if ($urandom_range(0, 2) == 0) begin
                vb = 2'($urandom_range(0, 3));
                idp = 1'($urandom); dp = 1'($urandom); dm = 1'($urandom);
            end
            w = ($urandom_range(0, 3) == 0);
            d = $urandom;
            if ($urandom_range(0, 1) == 0) d[11:8] = 4'h0;
            cyc(w, d);
        end
        finish_run();
    end
endmodule